// File: doc/BRIEF.md
# I2C Master Controller with Shared Byte FIFO

This block is a single-master I2C controller. It is driven through a small set of registers and moves bytes through one four-entry FIFO. The FIFO holds outgoing bytes during a write transfer and incoming bytes during a read transfer. Software loads the bytes to send and writes the target address, and the block then runs the whole transfer on its own. It generates START, the address frame, the data frames, the acknowledge bits and STOP. It also turns a pending STOP into a repeated START when software has already queued the next address.

SCL and SDA are driven in open-drain fashion. The block only ever pulls a line low, through `scl_oe` or `sda_oe`, and it reads the resolved SDA level on `sda_in`. SCL is derived from the system clock: each SCL period lasts four quarter-periods of `div+1` clock cycles. The register map is: 0 address, 1 read count, 2 data port, 3 status, 4 control, 5 divider.

Top module: `i2c_fifo_master`

## Requirements
- R1: Register 0 bits [7:1] carry the 7-bit target address. Bit 0 selects the direction, with 0 meaning write to the slave and 1 meaning read from the slave. The whole byte is sent MSB first as the first frame after START. Writing register 0 while idle begins a transfer.
- R2: A write transfer sends each FIFO byte as a 9-clock frame: eight data bits MSB first, then one acknowledge clock. When the FIFO runs empty after an acknowledged frame, the block issues STOP.
- R3: A read transfer receives the number of bytes set in register 1 into the FIFO. The master pulls SDA low (ACK) after every byte except the last one, releases SDA (NACK) after the last byte, and then issues STOP.
- R4: Writing register 0 while busy takes effect when the current transfer ends. At that point a repeated START with the new address replaces the STOP.
- R5: If the slave leaves any address or write-data frame unacknowledged, status bit 1 is set and STOP follows at once. Bytes still in the FIFO remain there.
- R6: Status bit 2 (receive-ready) is 1 when the FIFO is in receive direction and not empty. Status bit 3 (transmit-empty) is 1 when the FIFO is in transmit direction and empty. The FIFO takes the receive direction when a read transfer starts. It returns to the transmit direction when software pushes a byte or flushes.
- R7: Status bits [5:4] report the FIFO fill level: 00 when empty, 11 when holding 4 bytes, and 10 for any count in between. The code 01 never appears.
- R8: A write and a read of the data port in the same cycle set status bit 7 and change neither the FIFO contents nor the FIFO pointers.
- R9: A push while the FIFO is full, or while a read transfer is running, is discarded and sets status bit 6.
- R10: Writing 0 to status bit 1, 6 or 7 clears that bit. Writing 1 leaves it unchanged.
- R11: Status bit 0 (busy) is 1 from the cycle after a transfer begins until its STOP completes. During data and acknowledge bits, SDA changes only while SCL is low.
- R12: Writing 1 to control bit 0 empties the FIFO on the next cycle. The bit then reads back 0 again.
- R13: In a read, when the FIFO is full before a new byte begins, SCL is held low until software pops a byte. No received byte is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register index for the write |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe; a read of the data port pops a byte |
| rd_sel | input | 3 | Register index for the read |
| rd_data | output | 8 | Read data, combinational from rd_sel |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Resolved SDA line level |

## Verification
The assertions assume three things about the bus. The slave never holds SCL low. No other master drives START or STOP. SDA only moves from the slave side while SCL is low. The bench's slave model honours all three: it changes its SDA pull only on a falling SCL edge, and it never touches SCL. The assertions also assume that register writes to the address and divider arrive only at the moments the requirements name. The directed tasks issue such writes only while the block is idle, or well after the address frame has been loaded.

// File: rtl/i2c_fifo_master.sv
module i2c_fifo_master #(
  parameter int DEPTH = 4,
  parameter int DIV_W = 8,
  parameter logic [DIV_W-1:0] DIV_RST = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  input  logic [2:0] rd_sel,
  output logic [7:0] rd_data,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sda_in
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_BIT, S_STOP, S_RST} st_t;
  typedef enum logic [1:0] {K_ADDR, K_TX, K_RX} kind_t;

  st_t st;
  kind_t kind;
  logic [1:0] q;
  logic [3:0] bitn;
  logic [7:0] sh, addr_r, rcnt_r, nrx;
  logic cur_rd, rx_mode, pend, ackok;
  logic [DIV_W-1:0] div_r, dcnt;
  logic nack_f, acc_f, txw_f, flush_q;
  logic [7:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  wire busy   = st != S_IDLE;
  wire empty  = cnt == '0;
  wire full   = cnt == CW'(DEPTH);
  wire addr_w = wr_en && wr_sel == 3'd0;
  wire w_data = wr_en && wr_sel == 3'd2;
  wire r_data = rd_en && rd_sel == 3'd2;
  wire acc    = w_data && r_data;
  wire tick   = dcnt == div_r;
  wire stall  = st == S_BIT && kind == K_RX && bitn == 4'd0 && q == 2'd0 && full;
  wire adv    = tick && !stall;
  wire in_bit = st == S_BIT;
  wire [7:0] rx_byte = {sh[6:0], sda_in};

  wire eng_push = adv && in_bit && kind == K_RX && q == 2'd1 && bitn == 4'd7;
  wire byte_end = adv && in_bit && q == 2'd3 && bitn == 4'd8;
  wire wants_tx = kind != K_RX && ackok && !(kind == K_ADDR && cur_rd);
  wire eng_pop  = byte_end && wants_tx && !empty;
  wire nack_evt = byte_end && kind != K_RX && !ackok;
  wire rd_lock  = busy && cur_rd;
  wire sw_push  = w_data && !acc && !full && !rd_lock;
  wire sw_pop   = r_data && !acc && !empty && !(busy && !cur_rd);
  wire push     = eng_push || sw_push;
  wire pop      = eng_pop || sw_pop;
  wire [7:0] pdata = eng_push ? rx_byte : wr_data;
  wire st_t fin = pend ? S_RST : S_STOP;

  wire rx_irq = rx_mode && !empty;
  wire tx_irq = !rx_mode && empty;
  wire [1:0] fill = empty ? 2'b00 : (full ? 2'b11 : 2'b10);
  wire [7:0] status = {acc_f, txw_f, fill, tx_irq, rx_irq, nack_f, busy};

  // FIFO storage and pointers
  always_ff @(posedge clk) if (push && !flush_q) mem[wp] <= pdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else if (flush_q) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop) rp <= nxt(rp);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  // Software-visible registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_r <= '0; rcnt_r <= '0; div_r <= DIV_RST;
      nack_f <= 1'b0; acc_f <= 1'b0; txw_f <= 1'b0; flush_q <= 1'b0;
    end else begin
      flush_q <= wr_en && wr_sel == 3'd4 && wr_data[0];
      if (addr_w) addr_r <= wr_data;
      if (wr_en && wr_sel == 3'd1) rcnt_r <= wr_data;
      if (wr_en && wr_sel == 3'd5) div_r <= DIV_W'(wr_data);
      if (wr_en && wr_sel == 3'd3) begin
        nack_f <= nack_f & wr_data[1];
        txw_f  <= txw_f & wr_data[6];
        acc_f  <= acc_f & wr_data[7];
      end
      if (nack_evt) nack_f <= 1'b1;
      if (w_data && !acc && (full || rd_lock)) txw_f <= 1'b1;
      if (acc) acc_f <= 1'b1;
    end
  end

  // Bit and byte sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; kind <= K_ADDR; q <= '0; bitn <= '0; sh <= '0;
      nrx <= '0; cur_rd <= 1'b0; rx_mode <= 1'b0; pend <= 1'b0;
      ackok <= 1'b0; dcnt <= '0;
    end else begin
      dcnt <= (st == S_IDLE || tick) ? '0 : dcnt + 1'b1;
      if (sw_push || flush_q) rx_mode <= 1'b0;
      if (st == S_IDLE) begin
        q <= '0;
        if (addr_w) st <= S_START;
      end else if (adv) begin
        q <= q + 1'b1;
        case (st)
          S_START, S_RST: if (q == 2'd3) begin
            st <= S_BIT; kind <= K_ADDR; sh <= addr_r; bitn <= '0;
            cur_rd <= addr_r[0]; nrx <= '0; pend <= 1'b0;
            if (addr_r[0]) rx_mode <= 1'b1;
          end
          S_STOP: if (q == 2'd3) st <= S_IDLE;
          S_BIT: begin
            if (q == 2'd1) begin
              if (kind == K_RX) begin
                if (bitn != 4'd8) sh <= rx_byte;
                if (bitn == 4'd7) nrx <= nrx + 1'b1;
              end else if (bitn == 4'd8) begin
                ackok <= !sda_in;
              end
            end
            if (q == 2'd3) begin
              if (bitn != 4'd8) begin
                bitn <= bitn + 1'b1;
                if (kind != K_RX) sh <= {sh[6:0], 1'b0};
              end else begin
                bitn <= '0;
                if (kind != K_RX && !ackok) begin
                  st <= S_STOP; pend <= 1'b0;
                end else if (kind == K_ADDR && cur_rd) begin
                  if (rcnt_r == '0) st <= fin;
                  else kind <= K_RX;
                end else if (kind != K_RX) begin
                  if (!empty) begin sh <= mem[rp]; kind <= K_TX; end
                  else st <= fin;
                end else if (nrx == rcnt_r) begin
                  st <= fin;
                end
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
      if (addr_w && busy) pend <= 1'b1;
    end
  end

  wire bit_low = (kind == K_RX) ? (bitn == 4'd8 && nrx != rcnt_r)
                                : (bitn != 4'd8 && !sh[7]);

  always_comb begin
    case (st)
      S_START: begin scl_oe = q == 2'd3;                sda_oe = q != 2'd0; end
      S_BIT:   begin scl_oe = q == 2'd0 || q == 2'd3;   sda_oe = bit_low;   end
      S_STOP:  begin scl_oe = q == 2'd0;                sda_oe = q < 2'd2;  end
      S_RST:   begin scl_oe = q == 2'd0 || q == 2'd3;   sda_oe = q >= 2'd2; end
      default: begin scl_oe = 1'b0;                     sda_oe = 1'b0;      end
    endcase
  end

  always_comb begin
    case (rd_sel)
      3'd0: rd_data = addr_r;
      3'd1: rd_data = rcnt_r;
      3'd2: rd_data = empty ? 8'h00 : mem[rp];
      3'd3: rd_data = status;
      3'd4: rd_data = {7'b0, flush_q};
      3'd5: rd_data = 8'(div_r);
      default: rd_data = 8'h00;
    endcase
  end

  p_fill_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  p_sda_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_bit && !scl_oe && $past(in_bit) && $past(!scl_oe)) |-> $stable(sda_oe));
  p_busy_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && addr_w) |=> busy);
  p_nack_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nack_f) |-> st == S_STOP);
  p_acc_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> acc_f);
  p_push_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (w_data && !acc && full) |=> txw_f);
  p_flush_r12: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |=> cnt == '0);
  p_stall_r13: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> scl_oe);
endmodule

// File: tb/test_i2c_fifo_master.sv
module test_i2c_fifo_master;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] wr_sel = '0, rd_sel = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic scl_oe, sda_oe;
  logic s_pull = 1'b0;
  wire scl_w = !scl_oe;
  wire sda_w = !(sda_oe || s_pull);
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  i2c_fifo_master i_i2c_fifo_master (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_w));

  // Slave model at address 0x50
  int s_st = 0, s_bit = 0, s_wn = 0, s_ridx = 0;
  int s_starts = 0, s_stops = 0, s_macks = 0, s_mnacks = 0;
  logic s_skip = 1'b0, s_acked = 1'b0, s_dir = 1'b0, s_mack = 1'b0;
  logic [7:0] s_sh = '0, s_tx = '0, s_abyte = '0;
  logic [7:0] s_wbuf [16];

  always @(negedge sda_w) if (scl_w) begin
    s_starts++; s_st = 1; s_bit = 0; s_skip = 1'b1; s_pull = 1'b0;
  end
  always @(posedge sda_w) if (scl_w) begin
    s_stops++; s_st = 0; s_pull = 1'b0;
  end
  always @(posedge scl_w) if (s_st != 0) begin
    if (s_bit < 8) s_sh = {s_sh[6:0], sda_w};
    else if (s_st == 3) begin
      s_mack = !sda_w;
      if (s_mack) s_macks++; else s_mnacks++;
    end
  end
  always @(negedge scl_w) if (s_st != 0) begin
    if (s_skip) s_skip = 1'b0;
    else if (s_bit == 7) begin
      s_bit = 8;
      if (s_st == 1) begin
        s_abyte = s_sh; s_acked = s_sh[7:1] == 7'h50; s_pull = s_acked; s_dir = s_sh[0];
      end else if (s_st == 2) begin
        s_wbuf[s_wn % 16] = s_sh; s_wn++; s_pull = 1'b1;
      end else s_pull = 1'b0;
    end else if (s_bit == 8) begin
      s_bit = 0;
      if (s_st == 1) begin
        if (!s_acked) begin s_st = 0; s_pull = 1'b0; end
        else if (s_dir) begin s_st = 3; s_ridx = 0; s_tx = 8'hC0; s_pull = !s_tx[7]; end
        else begin s_st = 2; s_pull = 1'b0; end
      end else if (s_st == 2) s_pull = 1'b0;
      else if (s_mack) begin
        s_ridx++; s_tx = 8'hC0 + 8'(s_ridx); s_pull = !s_tx[7];
      end else begin s_st = 0; s_pull = 1'b0; end
    end else begin
      s_bit++;
      if (s_st == 3) s_pull = !s_tx[7 - s_bit];
    end
  end

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not complete (actual=hung expected=done)");
    summary();
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] sel, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] sel, output logic [7:0] v);
    @(negedge clk); rd_en = 1'b1; rd_sel = sel; #1 v = rd_data;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_idle(string req);
    logic [7:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd(3'd3, v);
      if (!v[0]) return;
    end
    chk(req, 8'h01, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(3'd3, v); chk("R6 reset status", v, 8'h08);
    chk("R11 reset lines", {6'b0, scl_oe, sda_oe}, 8'h00);
  endtask

  task automatic t_write();
    logic [7:0] v;
    int st0 = s_stops;
    s_wn = 0;
    wr(3'd2, 8'h3C); wr(3'd2, 8'hA5); wr(3'd2, 8'h01);
    wr(3'd0, 8'hA0);
    rd(3'd3, v); chk("R11 busy after start", {7'b0, v[0]}, 8'h01);
    wait_idle("R11 write end");
    chk("R1 address byte", s_abyte, 8'hA0);
    chk("R2 byte count", 8'(s_wn), 8'd3);
    chk("R2 byte0", s_wbuf[0], 8'h3C);
    chk("R2 byte1", s_wbuf[1], 8'hA5);
    chk("R2 byte2", s_wbuf[2], 8'h01);
    chk("R2 stop", 8'(s_stops - st0), 8'd1);
    rd(3'd3, v); chk("R7 R6 empty tx", v, 8'h08);
  endtask

  task automatic t_read();
    logic [7:0] v;
    int a0 = s_macks, n0 = s_mnacks;
    wr(3'd1, 8'd3); wr(3'd0, 8'hA1);
    wait_idle("R3 read end");
    chk("R1 read address", s_abyte, 8'hA1);
    chk("R3 acks", 8'(s_macks - a0), 8'd2);
    chk("R3 nacks", 8'(s_mnacks - n0), 8'd1);
    rd(3'd3, v); chk("R7 R6 rx ready", v, 8'h24);
    for (int i = 0; i < 3; i++) begin
      rd(3'd2, v); chk("R3 rx data", v, 8'hC0 + 8'(i));
    end
    rd(3'd3, v); chk("R6 rx drained", {7'b0, v[2]}, 8'h00);
  endtask

  task automatic t_nack();
    logic [7:0] v;
    int st0 = s_stops;
    wr(3'd2, 8'h77); wr(3'd0, 8'h44);
    wait_idle("R5 nack end");
    rd(3'd3, v);
    chk("R5 nack flag", {7'b0, v[1]}, 8'h01);
    chk("R5 fifo kept", {6'b0, v[5:4]}, 8'h02);
    chk("R5 stop", 8'(s_stops - st0), 8'd1);
    wr(3'd3, 8'hFF); rd(3'd3, v);
    chk("R10 write one keeps", {7'b0, v[1]}, 8'h01);
    wr(3'd3, 8'hFD); rd(3'd3, v);
    chk("R10 write zero clears", {7'b0, v[1]}, 8'h00);
    wr(3'd4, 8'h01);
  endtask

  task automatic t_errors();
    logic [7:0] v;
    for (int i = 0; i < 5; i++) wr(3'd2, 8'h10 + 8'(i));
    rd(3'd3, v);
    chk("R9 push full flag", {7'b0, v[6]}, 8'h01);
    chk("R7 full code", {6'b0, v[5:4]}, 8'h03);
    @(negedge clk); wr_en = 1'b1; wr_sel = 3'd2; wr_data = 8'hEE; rd_en = 1'b1; rd_sel = 3'd2;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    rd(3'd3, v);
    chk("R8 access flag", {7'b0, v[7]}, 8'h01);
    chk("R8 fill unchanged", {6'b0, v[5:4]}, 8'h03);
    wr(3'd3, 8'hBF); rd(3'd3, v);
    chk("R10 txw clear acc kept", {6'b0, v[7:6]}, 8'h02);
    wr(3'd3, 8'h7F); rd(3'd3, v);
    chk("R10 acc clear", {7'b0, v[7]}, 8'h00);
    for (int i = 0; i < 4; i++) begin
      rd(3'd2, v); chk("R9 R8 kept bytes", v, 8'h10 + 8'(i));
    end
    rd(3'd3, v); chk("R7 empty after pops", {6'b0, v[5:4]}, 8'h00);
  endtask

  task automatic t_flush();
    logic [7:0] v;
    wr(3'd2, 8'h55); wr(3'd2, 8'h66);
    wr(3'd4, 8'h01);
    rd(3'd4, v); chk("R12 self clear", v, 8'h00);
    rd(3'd3, v); chk("R12 flushed", {4'b0, v[5:4], v[3], 1'b0}, 8'h02);
  endtask

  task automatic t_restart();
    logic [7:0] v;
    int s0 = s_starts, p0 = s_stops;
    s_wn = 0;
    wr(3'd2, 8'h11); wr(3'd2, 8'h22); wr(3'd1, 8'd2);
    wr(3'd0, 8'hA0);
    repeat (60) @(negedge clk);
    wr(3'd0, 8'hA1);
    wait_idle("R4 restart end");
    chk("R4 starts", 8'(s_starts - s0), 8'd2);
    chk("R4 single stop", 8'(s_stops - p0), 8'd1);
    chk("R4 written", 8'(s_wn), 8'd2);
    chk("R4 wbyte1", s_wbuf[1], 8'h22);
    chk("R4 read address", s_abyte, 8'hA1);
    for (int i = 0; i < 2; i++) begin
      rd(3'd2, v); chk("R4 rx data", v, 8'hC0 + 8'(i));
    end
  endtask

  task automatic t_stall();
    logic [7:0] v;
    wr(3'd1, 8'd6); wr(3'd0, 8'hA1);
    repeat (3000) @(negedge clk);
    rd(3'd3, v);
    chk("R13 still busy", {7'b0, v[0]}, 8'h01);
    chk("R13 full", {6'b0, v[5:4]}, 8'h03);
    chk("R13 scl held", {7'b0, scl_oe}, 8'h01);
    for (int i = 0; i < 4; i++) begin
      rd(3'd2, v); chk("R13 data head", v, 8'hC0 + 8'(i));
    end
    wait_idle("R13 end");
    for (int i = 4; i < 6; i++) begin
      rd(3'd2, v); chk("R13 data tail", v, 8'hC0 + 8'(i));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_read();
    t_nack();
    t_errors();
    t_flush();
    t_restart();
    t_stall();
    summary();
  end
endmodule